// File: doc/BRIEF.md
# Prioritised Daisy-Chain Bus Arbiter

This block is the central arbiter of a shared bus whose devices are split across five request levels. One level serves non-processor (direct data) transfers. The other four serve interrupt-style requests, ranked 7 down to 4. Each cycle that it is idle, the arbiter looks at the request lines and picks the highest level that is allowed to win. It then raises the one grant line of that level. The grant travels down a daisy chain outside the block, and the first requesting device on that chain takes it by raising a selection acknowledge. Within a level, the position on the chain decides which device wins. Across levels, the level decides.

If no device acknowledges within a configurable number of cycles, the grant is treated as having run off the end of the chain. The arbiter withdraws it and arbitrates again from the current requests. After an acknowledge, the arbiter waits until the acknowledge is released and until the bus-busy line has been seen free since the acknowledge. The next master can therefore be chosen while the current master is still transferring. A processor priority input masks the four interrupt levels. The non-processor level is never masked.

The controller has three states. ST_IDLE moves to ST_GRANT on "pick" when any eligible request exists. ST_GRANT moves to ST_HOLD on "accept" when the acknowledge is high, and back to ST_IDLE on "expire" when the timeout ends without an acknowledge. ST_HOLD moves to ST_IDLE on "release" once the acknowledge is low and bus-busy has been seen low since the acknowledge.

Top module: `bus_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, no grant bit is set.
- R2: Request and grant bit 4 is the non-processor level. Bits 3..0 are levels 7..4, where bit i stands for level 4+i. When bit 4 requests, it is granted ahead of all other levels.
- R3: Among the interrupt levels, the highest requested level is granted (7 over 6 over 5 over 4).
- R4: An interrupt level L is granted only when L is strictly greater than cpu_lvl_i. A masked request is ignored, and the grant stays zero. The non-processor level is granted at any cpu_lvl_i, including 7.
- R5: At most one grant bit is set in any cycle.
- R6: A grant is raised one cycle after an eligible request is seen in ST_IDLE. It is cleared in the cycle after ack_i is seen high while it is raised.
- R7: After an acknowledge, no new grant is raised while ack_i stays high. No new grant is raised while busy_i has stayed high ever since the acknowledge.
- R8: Once the hold has been released, a new grant may be raised while busy_i is high, so that arbitration overlaps the ongoing transfer.
- R9: A grant with no acknowledge stays high for exactly TIMEOUT cycles. It is then low for one cycle, after which arbitration restarts on the requests present at that time.
- R10: An outstanding grant does not change when a higher-priority request arrives before it is acknowledged or expires.
- R11: ack_i has no effect in ST_IDLE. A request that arrives while ack_i is high is still granted on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_BR+1 | Request lines; bit 4 is non-processor, bit i (i<4) is level 4+i |
| cpu_lvl_i | input | LVL_W | Processor priority level used to mask interrupt levels |
| ack_i | input | 1 | Selection acknowledge from the device that took the grant |
| busy_i | input | 1 | Bus-busy, high while a master uses the data section |
| grant_o | output | NUM_BR+1 | Grant lines, same bit order as req_i, at most one high |

## Verification
The hardest situation to reach is the overlapped hand-over. A new master has acknowledged while the previous master still holds busy, and another request is already queued. The scenario keeps busy_i high from before the acknowledge and through its release, and it checks that no grant appears. It then drops busy_i for a single cycle and raises it again at once, standing in for the new master taking the bus. Only then should the queued lower level be granted, while busy_i is high. The timeout path is reached by asking on a level whose devices never answer. The request is swapped during the one idle cycle after expiry, to show that the restart uses fresh requests.

// File: rtl/arb_pkg.sv
package arb_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_HOLD  = 2'd2
    } arb_state_t;

    // Interrupt level carried by bit 0 of the request vector
    localparam int BR_BASE_LVL = 4;

endpackage

// File: rtl/arb_pick.sv
// Combinational level selection: non-processor bit first, then the
// highest interrupt level that exceeds the processor priority.
module arb_pick
    import arb_pkg::*;
#(
    parameter int NUM_BR = 4,
    parameter int LVL_W  = 3
) (
    input  logic [NUM_BR:0]   req_i,
    input  logic [LVL_W-1:0]  cpu_lvl_i,
    output logic [NUM_BR:0]   pick_o
);

    logic [NUM_BR-1:0] br_ok;

    generate
        for (genvar g = 0; g < NUM_BR; g++) begin : g_mask
            localparam int THIS_LVL = BR_BASE_LVL + g;
            assign br_ok[g] = req_i[g] && (int'(cpu_lvl_i) < THIS_LVL);
        end
    endgenerate

    always_comb begin
        logic found;
        pick_o = '0;
        found  = 1'b0;
        if (req_i[NUM_BR]) begin
            pick_o[NUM_BR] = 1'b1;
        end else begin
            for (int i = NUM_BR - 1; i >= 0; i--) begin
                if (br_ok[i] && !found) begin
                    pick_o[i] = 1'b1;
                    found     = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/arb_timer.sv
// Counts cycles spent with a grant raised; flags the last allowed cycle.
module arb_timer #(
    parameter int TIMEOUT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);

    localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT + 1) : 1;
    localparam logic [CW-1:0] LIM = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = run_i && (cnt_q == LIM);

endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
    import arb_pkg::*;
#(
    parameter int NUM_BR  = 4,
    parameter int LVL_W   = 3,
    parameter int TIMEOUT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_BR:0]   req_i,
    input  logic [LVL_W-1:0]  cpu_lvl_i,
    input  logic              ack_i,
    input  logic              busy_i,
    output logic [NUM_BR:0]   grant_o
);

    arb_state_t        state_q, state_d;
    logic [NUM_BR:0]   pick;
    logic [NUM_BR:0]   grant_q;
    logic              free_q;
    logic              expired;

    arb_pick #(
        .NUM_BR (NUM_BR),
        .LVL_W  (LVL_W)
    ) u_pick (
        .req_i     (req_i),
        .cpu_lvl_i (cpu_lvl_i),
        .pick_o    (pick)
    );

    arb_timer #(
        .TIMEOUT (TIMEOUT)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (state_q == ST_GRANT),
        .expired_o (expired)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (|pick) state_d = ST_GRANT;            // pick
            end
            ST_GRANT: begin
                if (ack_i)        state_d = ST_HOLD;      // accept
                else if (expired) state_d = ST_IDLE;      // expire
            end
            ST_HOLD: begin
                if (!ack_i && (free_q || !busy_i))
                    state_d = ST_IDLE;                    // release
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs and hold bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_q <= '0;
            free_q  <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && state_d == ST_GRANT)
                grant_q <= pick;
            else if (state_d != ST_GRANT)
                grant_q <= '0;

            unique case (state_q)
                ST_GRANT: free_q <= !busy_i;
                ST_HOLD:  free_q <= free_q || !busy_i;
                default:  free_q <= 1'b0;
            endcase
        end
    end

    assign grant_o = grant_q;

endmodule

// File: rtl/bus_arbiter_chk.sv
module bus_arbiter_chk
    import arb_pkg::*;
#(
    parameter int NUM_BR  = 4,
    parameter int LVL_W   = 3,
    parameter int TIMEOUT = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_BR:0]   req_i,
    input logic [LVL_W-1:0]  cpu_lvl_i,
    input logic              ack_i,
    input logic [NUM_BR:0]   grant_o
);

    localparam int CW = $clog2(TIMEOUT + 2);

    logic [CW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   hi_cnt <= '0;
        else if (grant_o == '0)       hi_cnt <= '0;
        else if (hi_cnt != {CW{1'b1}}) hi_cnt <= hi_cnt + 1'b1;
    end

    // R5
    onehot_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // R6
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_o != '0) && ack_i) |=> (grant_o == '0));

    // R2
    grant_requested_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_o != '0) && ($past(grant_o) == '0)) |-> ((grant_o & $past(req_i)) == grant_o));

    // R10
    grant_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_o != '0) && ($past(grant_o) != '0)) |-> (grant_o == $past(grant_o)));

    // R9
    timeout_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(hi_cnt) <= TIMEOUT));

    generate
        for (genvar g = 0; g < NUM_BR; g++) begin : g_lvl
            // R4
            mask_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (grant_o[g] && !$past(grant_o[g])) |-> (int'($past(cpu_lvl_i)) < BR_BASE_LVL + g));
        end
    endgenerate

endmodule

bind bus_arbiter bus_arbiter_chk #(
    .NUM_BR  (NUM_BR),
    .LVL_W   (LVL_W),
    .TIMEOUT (TIMEOUT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .cpu_lvl_i (cpu_lvl_i),
    .ack_i     (ack_i),
    .grant_o   (grant_o)
);

// File: tb/bus_arbiter_tb.sv
`timescale 1ns/1ps
module bus_arbiter_tb;

    localparam int TO = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] req = '0;
    logic [2:0] lvl = '0;
    logic       ack = 1'b0;
    logic       busy = 1'b0;
    logic [4:0] grant;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bus_arbiter #(.NUM_BR(4), .LVL_W(3), .TIMEOUT(TO)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req),
        .cpu_lvl_i (lvl),
        .ack_i     (ack),
        .busy_i    (busy),
        .grant_o   (grant)
    );

    task automatic check(string tag, logic [4:0] got, logic [4:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: grant=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    // Acknowledge the outstanding grant, then clear everything.
    task automatic take(string tag);
        ack = 1'b1;
        nxt();
        check({tag, " R6 drop"}, grant, 5'b00000);
        ack = 1'b0; req = '0; busy = 1'b0;
        nxt(); nxt();
    endtask

    task automatic single(string tag, logic [4:0] r, logic [2:0] l, logic [4:0] exp);
        req = r; lvl = l;
        nxt();
        check(tag, grant, exp);
        if (exp != '0) take(tag);
        else begin
            nxt(); check(tag, grant, 5'b00000);
            nxt(); check(tag, grant, 5'b00000);
            req = '0; nxt();
        end
    endtask

    task automatic t_reset();
        req = 5'b11111;
        repeat (3) nxt();
        check("R1 in reset", grant, 5'b00000);
        rst_n = 1'b1;
        check("R1 release", grant, 5'b00000);
        req = '0;
        nxt(); nxt();
        check("R1 after", grant, 5'b00000);
    endtask

    task automatic t_priority();
        req = 5'b11111; lvl = 3'd0;
        nxt();
        check("R2 npr first", grant, 5'b10000);
        n_cmp++;
        if ($countones(grant) > 1) begin
            n_bad++;
            $display("FAIL R5: ones=%0d expected<=1", $countones(grant));
        end
        take("R2");
        single("R3 lvl7", 5'b01111, 3'd0, 5'b01000);
        single("R3 lvl6", 5'b00110, 3'd0, 5'b00100);
        single("R3 lvl5", 5'b00011, 3'd0, 5'b00010);
        single("R3 lvl4", 5'b00001, 3'd0, 5'b00001);
    endtask

    task automatic t_mask();
        single("R4 lvl6 over cpu5", 5'b00111, 3'd5, 5'b00100);
        single("R4 all masked cpu6", 5'b00111, 3'd6, 5'b00000);
        single("R4 lvl7 masked cpu7", 5'b01000, 3'd7, 5'b00000);
        single("R4 npr unmasked cpu7", 5'b10000, 3'd7, 5'b10000);
        lvl = 3'd0;
    endtask

    task automatic t_overlap();
        req = 5'b00011;
        nxt();
        check("R7 first grant", grant, 5'b00010);
        ack = 1'b1; busy = 1'b1; req = 5'b00001;
        nxt(); check("R6 acked", grant, 5'b00000);
        nxt(); check("R7 ack held", grant, 5'b00000);
        nxt(); check("R7 ack held", grant, 5'b00000);
        ack = 1'b0;
        for (int k = 0; k < 3; k++) begin
            nxt(); check("R7 busy never free", grant, 5'b00000);
        end
        busy = 1'b0;
        nxt();
        busy = 1'b1;
        nxt();
        check("R8 grant during busy", grant, 5'b00001);
        take("R8");
    endtask

    task automatic t_timeout();
        req = 5'b01000;
        for (int k = 1; k <= TO; k++) begin
            nxt(); check("R9 held", grant, 5'b01000);
        end
        nxt(); check("R9 cancelled", grant, 5'b00000);
        req = 5'b10000;
        nxt(); check("R9 restart fresh", grant, 5'b10000);
        take("R9");
    endtask

    task automatic t_no_preempt();
        req = 5'b00001;
        nxt(); check("R10 base", grant, 5'b00001);
        req = 5'b10001;
        for (int k = 0; k < 3; k++) begin
            nxt(); check("R10 not preempted", grant, 5'b00001);
        end
        ack = 1'b1;
        nxt(); check("R10 acked", grant, 5'b00000);
        ack = 1'b0; req = 5'b10000;
        nxt(); nxt();
        check("R10 npr next", grant, 5'b10000);
        take("R10");
    endtask

    task automatic t_idle_ack();
        ack = 1'b1; req = '0;
        for (int k = 0; k < 3; k++) begin
            nxt(); check("R11 idle ack", grant, 5'b00000);
        end
        req = 5'b00100;
        nxt(); check("R11 grant despite ack", grant, 5'b00100);
        nxt(); check("R11 R6 drop", grant, 5'b00000);
        ack = 1'b0; req = '0;
        nxt(); nxt();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_priority();
        t_mask();
        t_overlap();
        t_timeout();
        t_no_preempt();
        t_idle_ack();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule